// File: doc/BRIEF.md
# Two-Wire Serial Slave with Register-File Access

This block is a slave on a two-wire open-drain serial bus. It gives an external master read and write access to a register file of up to 128 byte-wide entries. The register file sits beside the block and is reached through a simple parallel request port. The two bus lines arrive as raw inputs and pass through a two-stage synchroniser. The system clock samples them many times per bus bit. The block drives the bus only by pulling low: `sda_oe` pulls the data line and `scl_hold` pulls the clock line.

A transaction opens with a START condition, followed by an address byte. The upper seven bits of that byte must equal the `DEV_ADDR` parameter, and the lowest bit selects the direction. A write transaction carries a sub-address byte next. Bits 6:0 of the sub-address load an internal register pointer. Bit 7 decides whether the pointer moves on after each data byte or stays on one register. Data bytes that follow are written at the pointer. To read, the master sends the sub-address in a write phase, then issues a repeated START and the address with the read bit set. The block then returns register contents for as long as the master keeps acknowledging.

When a register access is still outstanding at the end of an acknowledge clock, the block stretches the bus clock by holding SCL low until the register file answers.

Top module: `i2c_regif`

## Requirements
- R1: A START (data line falling while the clock line is high) at any point, including in the middle of a byte, restarts reception of an address byte. A STOP (data line rising while the clock line is high) returns the block to idle with the data line released.
- R2: An address byte whose bits 7:1 equal `DEV_ADDR` is acknowledged by holding `sda_oe` high through the ninth clock. Bit 0 of that byte is 0 for a write and 1 for a read.
- R3: After an address byte that does not match, the block acknowledges nothing and leaves both lines released. It makes no register access until the next START.
- R4: The sub-address byte that follows a write address is acknowledged. Its bits 6:0 load the register pointer.
- R5: Each data byte of a write is received most significant bit first and acknowledged. It is written once, through `reg_wr`, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: When bit 7 of the sub-address is 1, the pointer advances by one after each byte written or returned, wrapping from 127 to 0. When bit 7 is 0, every byte of the transaction uses the same register.
- R7: After a repeated START and a matching address with bit 0 set to 1, the block returns the register at the pointer, most significant bit first. Each byte is fetched into the transmit shift register before its first bit is driven.
- R8: A master acknowledge (data line low on the ninth clock of a returned byte) makes the block fetch and send the next byte. A master no-acknowledge ends the read: the data line stays released and no further register read is issued.
- R9: If the register access for a byte is not finished when the acknowledge clock ends, the block pulls SCL low (`scl_hold` = 1). It releases SCL only after `reg_ready` has answered. It raises `scl_hold` only while the bus clock is low.
- R10: The block changes `sda_oe` only while the synchronised clock line is low, except when it releases the line on a START or STOP. Both bus inputs pass through two flip-flops before any use.
- R11: At most one of `reg_rd` and `reg_wr` is high at a time. A request stays high, with a stable address and write data, until the cycle in which `reg_ready` is 1.
- R12: While `rst` is high and in the cycle after it, `sda_oe`, `scl_hold`, `reg_rd` and `reg_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level as seen on the wire |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_hold | output | 1 | 1 pulls the clock line low (stretching) |
| reg_addr | output | 7 | Register index of the current request |
| reg_wr | output | 1 | Write request, held until `reg_ready` |
| reg_rd | output | 1 | Read request, held until `reg_ready` |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Read data, valid while `reg_ready` is 1 |
| reg_ready | input | 1 | Completes the pending request in this cycle |

## Verification
Two functions can land in the same system-clock cycle: the register file's answer (`reg_ready`), and the falling clock edge that ends an acknowledge clock. On that edge the block decides whether to stretch and which data to load. The bench varies the register-file latency from one cycle up to more than a whole bus bit, so that the answer falls before, on, or after that edge, and in some cases only on the master-acknowledge clock. Each case is judged at the pins. The returned and written bytes must be correct, and `scl_hold` must appear when the latency exceeds the acknowledge window and never when the answer is fast.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;
    localparam int CNT_W  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX,
        ST_RXEND,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_MACK2,
        ST_HOLD,
        ST_REL,
        ST_IGNORE
    } phase_t;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_SUB,
        RL_DATA
    } role_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } cond_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [PTR_W-1:0]  addr;
        logic [BYTE_W-1:0] wdata;
    } acc_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [PTR_W-1:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p, input logic inc);
        return p + {{(PTR_W-1){1'b0}}, inc};
    endfunction

endpackage

// File: rtl/i2c_regif_sync.sv
module i2c_regif_sync
    import i2c_regif_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t raw,
    output line_t synced
);

    line_t pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign synced = pipe[STAGES-1];

endmodule

// File: rtl/i2c_regif_cond.sv
module i2c_regif_cond
    import i2c_regif_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t now,
    output cond_t ev
);

    line_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= now;
    end

    always_comb begin
        ev.rise  = now.scl & ~prev.scl;
        ev.fall  = ~now.scl & prev.scl;
        ev.start = now.scl & prev.scl & prev.sda & ~now.sda;
        ev.stop  = now.scl & prev.scl & ~prev.sda & now.sda;
    end

endmodule

// File: rtl/i2c_regif_ctrl.sv
module i2c_regif_ctrl
    import i2c_regif_pkg::*;
#(
    parameter logic [PTR_W-1:0] DEV_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  line_t             line,
    input  cond_t             ev,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic              reg_ready,
    output logic              sda_oe,
    output logic              scl_hold,
    output acc_t              acc
);

    phase_t            st;
    role_t             role;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] rbuf;
    logic [PTR_W-1:0]  ptr;
    logic              inc;
    logic              nxt_tx;

    logic              acc_pend;
    logic              acc_busy;
    logic [BYTE_W-1:0] rd_now;

    assign acc_pend = acc.rd | acc.wr;
    assign acc_busy = acc_pend & ~reg_ready;
    assign rd_now   = (acc.rd & reg_ready) ? reg_rdata : rbuf;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            role     <= RL_ADDR;
            bitcnt   <= '0;
            sh       <= '0;
            tx       <= '0;
            rbuf     <= '0;
            ptr      <= '0;
            inc      <= 1'b0;
            nxt_tx   <= 1'b0;
            sda_oe   <= 1'b0;
            scl_hold <= 1'b0;
            acc      <= '0;
        end else begin
            // completion of the pending register access
            if (acc_pend && reg_ready) begin
                if (acc.rd) rbuf <= reg_rdata;
                if (acc.wr) ptr  <= step_ptr(ptr, inc);
                acc.rd <= 1'b0;
                acc.wr <= 1'b0;
            end

            if (ev.stop) begin
                st       <= ST_IDLE;
                sda_oe   <= 1'b0;
                scl_hold <= 1'b0;
            end else if (ev.start) begin
                st       <= ST_RX;
                role     <= RL_ADDR;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                scl_hold <= 1'b0;
            end else begin
                case (st)
                    ST_RX: if (ev.rise) begin
                        sh     <= {sh[BYTE_W-2:0], line.sda};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == CNT_W'(BYTE_W-1)) st <= ST_RXEND;
                    end
                    ST_RXEND: if (ev.fall) begin
                        case (role)
                            RL_ADDR: begin
                                if (addr_hit(sh, DEV_ADDR)) begin
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    nxt_tx <= sh[0];
                                    if (sh[0]) begin
                                        acc.rd   <= 1'b1;
                                        acc.addr <= ptr;
                                    end else begin
                                        role <= RL_SUB;
                                    end
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end
                            RL_SUB: begin
                                ptr    <= sh[PTR_W-1:0];
                                inc    <= sh[BYTE_W-1];
                                sda_oe <= 1'b1;
                                nxt_tx <= 1'b0;
                                role   <= RL_DATA;
                                st     <= ST_ACK;
                            end
                            default: begin
                                acc.wr    <= 1'b1;
                                acc.addr  <= ptr;
                                acc.wdata <= sh;
                                sda_oe    <= 1'b1;
                                nxt_tx    <= 1'b0;
                                st        <= ST_ACK;
                            end
                        endcase
                    end
                    ST_ACK, ST_MACK2: if (ev.fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (acc_busy) begin
                            scl_hold <= 1'b1;
                            st       <= ST_HOLD;
                        end else if (nxt_tx) begin
                            tx     <= rd_now;
                            ptr    <= step_ptr(ptr, inc);
                            sda_oe <= ~rd_now[BYTE_W-1];
                            st     <= ST_TX;
                        end else begin
                            st <= ST_RX;
                        end
                    end
                    ST_HOLD: if (!acc_busy) begin
                        if (nxt_tx) begin
                            tx     <= rd_now;
                            ptr    <= step_ptr(ptr, inc);
                            sda_oe <= ~rd_now[BYTE_W-1];
                            st     <= ST_REL;
                        end else begin
                            scl_hold <= 1'b0;
                            st       <= ST_RX;
                        end
                    end
                    ST_REL: begin
                        scl_hold <= 1'b0;
                        st       <= ST_TX;
                    end
                    ST_TX: begin
                        if (ev.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall) begin
                            if (bitcnt == CNT_W'(BYTE_W)) begin
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: if (ev.rise) begin
                        if (!line.sda) begin
                            acc.rd   <= 1'b1;
                            acc.addr <= ptr;
                            st       <= ST_MACK2;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: data line moves only while the clock line is low, START/STOP release aside
    p_sda_on_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!$past(line.scl) || $past(ev.start) || $past(ev.stop)));

    // R9: stretching begins only with the clock line already low
    p_hold_on_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_hold) |-> !$past(line.scl));

    // R9: the hold state always has an access outstanding
    p_hold_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD) |-> (acc.rd || acc.wr));

    // R11: never both request kinds
    p_one_req_r11: assert property (@(posedge clk) disable iff (rst)
        !(acc.rd && acc.wr));

    // R11: request is held steady until answered
    p_req_steady_r11: assert property (@(posedge clk) disable iff (rst)
        ((acc.rd || acc.wr) && !reg_ready) |=>
            ((acc.rd || acc.wr) && $stable(acc.addr) && $stable(acc.wdata)));

    // R3: an ignored transaction leaves both lines alone
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> (!sda_oe && !scl_hold));

    // R8: the master-acknowledge slot is never driven by the slave
    p_mack_released_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MACK) |-> !sda_oe);

endmodule

// File: rtl/i2c_regif.sv
module i2c_regif
    import i2c_regif_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3A,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       scl_hold,
    output logic [6:0] reg_addr,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    input  logic       reg_ready
);

    line_t raw_line;
    line_t sync_line;
    cond_t ev;
    acc_t  acc;

    assign raw_line.scl = scl_i;
    assign raw_line.sda = sda_i;

    i2c_regif_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (raw_line),
        .synced (sync_line)
    );

    i2c_regif_cond u_cond (
        .clk (clk),
        .rst (rst),
        .now (sync_line),
        .ev  (ev)
    );

    i2c_regif_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .line      (sync_line),
        .ev        (ev),
        .reg_rdata (reg_rdata),
        .reg_ready (reg_ready),
        .sda_oe    (sda_oe),
        .scl_hold  (scl_hold),
        .acc       (acc)
    );

    assign reg_addr  = acc.addr;
    assign reg_wr    = acc.wr;
    assign reg_rd    = acc.rd;
    assign reg_wdata = acc.wdata;

    // R12: outputs quiet right after reset
    p_reset_quiet_r12: assert property (@(posedge clk)
        rst |=> (!sda_oe && !scl_hold && !reg_rd && !reg_wr));

endmodule

// File: tb/i2c_regif_test.sv
module i2c_regif_test;

    localparam logic [6:0] DEV = 7'h3A;
    localparam int Q = 10;

    typedef struct packed {
        logic [7:0] lat;
        logic       rd;
        logic       inc;
        logic [1:0] hexp;   // 0 no stretch, 1 stretch, 2 either
        logic [6:0] base;
        logic [3:0] cnt;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{8'd0,  1'b0, 1'b1, 2'd0, 7'h10, 4'd4},
        '{8'd0,  1'b1, 1'b1, 2'd0, 7'h10, 4'd4},
        '{8'd50, 1'b0, 1'b0, 2'd1, 7'h20, 4'd3},
        '{8'd50, 1'b1, 1'b0, 2'd1, 7'h20, 4'd2},
        '{8'd3,  1'b0, 1'b1, 2'd0, 7'h7E, 4'd4},
        '{8'd30, 1'b1, 1'b1, 2'd1, 7'h7E, 4'd4},
        '{8'd1,  1'b0, 1'b0, 2'd0, 7'h05, 4'd1},
        '{8'd15, 1'b1, 1'b0, 2'd2, 7'h05, 4'd1}
    };

    logic clk = 1'b0;
    logic rst;
    logic m_scl, m_sda;
    logic sda_oe, scl_hold, reg_wr, reg_rd, reg_ready;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic scl_line, sda_line;

    assign scl_line = m_scl & ~scl_hold;
    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    i2c_regif #(.DEV_ADDR(DEV)) uut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .scl_hold  (scl_hold),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_ready (reg_ready)
    );

    // register file model with adjustable latency
    logic [7:0] mem [128];
    logic [7:0] exp_mem [128];
    int lat = 0;
    int wait_c = 0;
    int rd_count = 0, wr_count = 0, hold_cycles = 0, viol = 0;
    logic prev_oe = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            reg_ready <= 1'b0;
            reg_rdata <= 8'h00;
            wait_c    <= 0;
            for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 3 + 1);
        end else if (reg_ready) begin
            reg_ready <= 1'b0;
            wait_c    <= 0;
        end else if (reg_rd || reg_wr) begin
            if (wait_c >= lat) begin
                reg_ready <= 1'b1;
                if (reg_wr) begin
                    mem[reg_addr] <= reg_wdata;
                    wr_count <= wr_count + 1;
                end else begin
                    reg_rdata <= mem[reg_addr];
                    rd_count <= rd_count + 1;
                end
            end else begin
                wait_c <= wait_c + 1;
            end
        end
        if (scl_hold) hold_cycles <= hold_cycles + 1;
    end

    // R10 monitor: sda_oe must not move while the clock line is high
    always @(negedge clk) begin
        if (!rst && (sda_oe !== prev_oe) && scl_line) viol <= viol + 1;
        prev_oe <= sda_oe;
    end

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_rstart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; wait_high(); tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; wait_high(); tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic m_bit(input logic b, output logic r);
        m_sda = b; tick(Q);
        m_scl = 1'b1; wait_high(); tick(Q);
        r = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic d;
        for (int i = 7; i >= 0; i--) m_bit(b[i], d);
        m_bit(1'b1, ack);
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] v);
        logic d;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, d);
            v[i] = d;
        end
        m_bit(mack, d);
    endtask

    function automatic logic [7:0] data_of(input int k, input int i);
        return 8'(165 ^ (k * 29) ^ (i * 7));
    endfunction

    function automatic bit mem_match();
        for (int i = 0; i < 128; i++) if (mem[i] !== exp_mem[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic run_vec(input int k);
        vec_t v;
        logic ack;
        logic [7:0] got;
        logic [6:0] a;
        int rd0, wr0, h0;
        v = VEC[k];
        lat = int'(v.lat);
        rd0 = rd_count; wr0 = wr_count; h0 = hold_cycles;
        m_start();
        wbyte({DEV, 1'b0}, ack);
        chk(ack == 1'b0, "R2 address ack", int'(ack), 0);
        wbyte({v.inc, v.base}, ack);
        chk(ack == 1'b0, "R4 sub-address ack", int'(ack), 0);
        if (!v.rd) begin
            for (int i = 0; i < int'(v.cnt); i++) begin
                wbyte(data_of(k, i), ack);
                chk(ack == 1'b0, "R5 data ack", int'(ack), 0);
                a = v.inc ? 7'(int'(v.base) + i) : v.base;
                exp_mem[a] = data_of(k, i);
            end
            m_stop();
            tick(4);
            chk(mem_match(), "R5/R6 register contents", k, k);
            chk(wr_count - wr0 == int'(v.cnt), "R11 one write per byte", wr_count - wr0, int'(v.cnt));
            chk(sda_oe == 1'b0, "R1 released after stop", int'(sda_oe), 0);
        end else begin
            m_rstart();
            wbyte({DEV, 1'b1}, ack);
            chk(ack == 1'b0, "R2 read address ack", int'(ack), 0);
            for (int i = 0; i < int'(v.cnt); i++) begin
                rbyte((i == int'(v.cnt) - 1), got);
                a = v.inc ? 7'(int'(v.base) + i) : v.base;
                chk(got == exp_mem[a], "R7/R6 read byte", int'(got), int'(exp_mem[a]));
            end
            chk(sda_oe == 1'b0, "R8 released after nack", int'(sda_oe), 0);
            m_stop();
            tick(4);
            chk(rd_count - rd0 == int'(v.cnt), "R8 reads issued", rd_count - rd0, int'(v.cnt));
        end
        if (v.hexp == 2'd1)
            chk(hold_cycles - h0 > 0, "R9 stretch expected", hold_cycles - h0, 1);
        else if (v.hexp == 2'd0)
            chk(hold_cycles - h0 == 0, "R9 no stretch", hold_cycles - h0, 0);
    endtask

    initial begin
        logic ack, d;
        int wr0, rd0;
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
        for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i * 3 + 1);
        tick(5);
        chk(!sda_oe && !scl_hold && !reg_rd && !reg_wr, "R12 reset outputs",
            int'({sda_oe, scl_hold, reg_rd, reg_wr}), 0);
        rst = 1'b0;
        tick(5);
        chk(!sda_oe && !scl_hold && !reg_rd && !reg_wr, "R12 after reset",
            int'({sda_oe, scl_hold, reg_rd, reg_wr}), 0);

        for (int k = 0; k < 8; k++) run_vec(k);

        // R3: foreign address is not acknowledged and touches nothing
        lat = 2;
        wr0 = wr_count; rd0 = rd_count;
        m_start();
        wbyte({DEV ^ 7'h01, 1'b0}, ack);
        chk(ack == 1'b1, "R3 no ack on mismatch", int'(ack), 1);
        wbyte(8'h40, ack);
        chk(ack == 1'b1, "R3 later byte ignored", int'(ack), 1);
        wbyte(8'hC3, ack);
        m_stop();
        tick(4);
        chk((wr_count == wr0) && (rd_count == rd0), "R3 no access", wr_count - wr0, 0);
        chk(mem_match(), "R3 registers unchanged", 0, 0);

        // R1: START in the middle of a data byte restarts address reception
        wr0 = wr_count;
        m_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h30, ack);
        m_bit(1'b0, d); m_bit(1'b1, d); m_bit(1'b0, d);
        m_rstart();
        wbyte({DEV, 1'b0}, ack);
        chk(ack == 1'b0, "R1 address after mid-byte start", int'(ack), 0);
        wbyte(8'h31, ack);
        wbyte(8'h77, ack);
        m_stop();
        tick(4);
        exp_mem[7'h31] = 8'h77;
        chk(mem[7'h30] == exp_mem[7'h30], "R1 aborted byte not written", int'(mem[7'h30]), int'(exp_mem[7'h30]));
        chk(mem[7'h31] == 8'h77, "R1 write after restart", int'(mem[7'h31]), 'h77);
        chk(wr_count - wr0 == 1, "R1 single write", wr_count - wr0, 1);

        chk(viol == 0, "R10 sda changed with clock high", viol, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule